// File: doc/BRIEF.md
# Level-Sensitive Platform Interrupt Controller

This block gathers level interrupt lines from a set of sources and raises one interrupt request per hart context. Software reaches it through a plain 32-bit register port with separate read and write strobes. Each source has a small priority value. Each context has its own enable vector, its own threshold and a combined claim/complete register. A per-source gateway latches a request into a pending bit. After a claim it holds the source off until software completes it.

A handler reads the claim register of its context. The read returns the best eligible source ID and takes that source out of pending in the same cycle. The handler services the source, then writes the same ID back to finish. It repeats the read until it returns 0. ID 0 is reserved and means "nothing to take".

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every priority, enable bit and threshold is 0, no source is pending or held, every `irq_o` bit is low and a claim read returns 0.
- R2: Register layout (byte addresses, word aligned):
  - The priority of source ID n is at 4·n and keeps PW bits; the upper bits read 0.
  - The enable vector of context c starts at 0x2000 + 0x80·c. ID n sits in word n/32 at bit n%32, and bits for IDs above N_SRC read 0.
  - The threshold of context c is at 0x200000 + 0x1000·c and keeps PW bits. Its claim/complete register is 4 bytes above that.
- R3: Addresses outside the map read 0, and writes to them change nothing. This covers ID 0's priority slot, enable bit 0, enable words beyond the last ID, contexts past N_CTX and control offsets other than 0 and 4.
- R4: A source is eligible for context c when all three hold: it is pending, it is enabled in c, and its priority is strictly greater than c's threshold. `irq_o[c]` is high exactly when some source is eligible for c, and it follows the registered state with no extra cycle. A priority of 0 never fires.
- R5: A claim read returns, on `bus_rdata` in the cycle after the strobe, the eligible ID with the highest priority. Among equal priorities it returns the lowest ID. It returns 0 when none is eligible. Repeated claims therefore drain sources in that order.
- R6: A claim clears the returned source's pending bit and holds the source. While held, the source is not pending again, even if its line stays high.
- R7: Writing a held source's ID to the claim/complete register of a context that enables it releases the source. If its line is still high, it is pending again one cycle later. A source that rises while idle becomes pending at the next clock edge. `src_i[n]` is the line of ID n.
- R8: A completion write is ignored when its ID is 0, greater than N_SRC, or not enabled in the addressed context.
- R9: A claim by one context removes the source from every context's eligibility. A later claim elsewhere returns 0 or a different ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC (N_SRC:1) | Level interrupt lines, bit n is source ID n |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a claim read has a side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | N_CTX | Interrupt request per context |

## Verification
The latencies the bench relies on are these:
- A source line is latched into pending at the first edge that sees it, and `irq_o` follows that latch with no extra cycle. The bench therefore checks the request at the falling edge after one rising edge.
- Read data, including a claim's ID, appears after the edge that takes the strobe. The read task samples it at the next falling edge.
- A completion releases the gateway at its write edge, and the still-high line re-pends only at the following edge. The bench waits one extra cycle before it checks the request or claims again.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int N_SRC = 31,
  parameter int N_CTX = 2,
  parameter int PW    = 3,
  parameter int AW    = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC:1]    src_i,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_CTX-1:0]  irq_o
);
  localparam int IDW = $clog2(N_SRC + 1);
  localparam int NW  = (N_SRC + 32) / 32;
  localparam int NB  = NW * 32;
  localparam logic [31:0] EN_BASE  = 32'h0000_2000;
  localparam logic [31:0] CTL_BASE = 32'h0020_0000;
  localparam logic [31:0] EN_END   = EN_BASE + 32'(N_CTX * 128);
  localparam logic [31:0] CTL_END  = CTL_BASE + 32'(N_CTX * 4096);

  logic [PW-1:0]  prio [1:N_SRC];
  logic [NB-1:0]  en   [N_CTX];
  logic [PW-1:0]  thr  [N_CTX];
  logic [N_SRC:1] pend, busy;
  logic [IDW-1:0] best_id [N_CTX];

  logic [31:0] a, rd_val;
  int          pid, ectx, eword, cctx, wid;
  logic        p_hit, e_hit, t_hit, c_hit, w_ok;

  always_comb begin
    a     = 32'(bus_addr);
    pid   = int'(a[11:2]);
    eword = int'(a[6:2]);
    ectx  = int'((a - EN_BASE) >> 7);
    cctx  = int'((a - CTL_BASE) >> 12);
    p_hit = (a < 32'h1000) && (pid >= 1) && (pid <= N_SRC);
    e_hit = (a >= EN_BASE) && (a < EN_END) && (eword < NW);
    t_hit = (a >= CTL_BASE) && (a < CTL_END) && (a[11:0] == 12'h000);
    c_hit = (a >= CTL_BASE) && (a < CTL_END) && (a[11:0] == 12'h004);
    wid   = int'(bus_wdata[IDW-1:0]);
    w_ok  = (bus_wdata >= 32'd1) && (bus_wdata <= 32'(N_SRC));
  end

  always_comb begin
    logic [PW-1:0] lvl;
    for (int c = 0; c < N_CTX; c++) begin
      lvl        = thr[c];
      best_id[c] = '0;
      for (int i = 1; i <= N_SRC; i++)
        if (pend[i] && en[c][i] && prio[i] > lvl) begin
          lvl        = prio[i];
          best_id[c] = IDW'(i);
        end
      irq_o[c] = best_id[c] != '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (p_hit)      rd_val = 32'(prio[pid]);
    else if (e_hit) rd_val = en[ectx][eword*32 +: 32];
    else if (t_hit) rd_val = 32'(thr[cctx]);
    else if (c_hit) rd_val = 32'(best_id[cctx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      busy      <= '0;
      bus_rdata <= '0;
      for (int i = 1; i <= N_SRC; i++) prio[i] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      pend <= pend | (src_i & ~busy);
      if (bus_rd) begin
        bus_rdata <= rd_val;
        if (c_hit && best_id[cctx] != '0) begin
          pend[best_id[cctx]] <= 1'b0;
          busy[best_id[cctx]] <= 1'b1;
        end
      end
      if (bus_wr) begin
        if (p_hit) prio[pid] <= bus_wdata[PW-1:0];
        if (e_hit)
          for (int b = 0; b < 32; b++)
            en[ectx][eword*32+b] <= bus_wdata[b] && (eword*32+b >= 1) && (eword*32+b <= N_SRC);
        if (t_hit) thr[cctx] <= bus_wdata[PW-1:0];
        if (c_hit && w_ok && en[cctx][wid]) busy[wid] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int N_SRC = 31,
  parameter int N_CTX = 2,
  parameter int AW    = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic [N_CTX-1:0] irq_o,
  input logic [N_SRC:1]   pend,
  input logic [N_SRC:1]   busy
);
  localparam int IDW = $clog2(N_SRC + 1);

  p_held_not_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0);

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> irq_o == '0);

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic claim;
    assign claim = bus_rd && (32'(bus_addr) == 32'h0020_0004 + 32'(c * 4096));

    p_empty_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      claim && !irq_o[c] |=> bus_rdata == 32'd0);

    p_live_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      claim && irq_o[c] |=> (bus_rdata != 32'd0) && (bus_rdata <= 32'(N_SRC)));

    p_claim_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      claim && irq_o[c] |=> busy[bus_rdata[IDW-1:0]] && !pend[bus_rdata[IDW-1:0]]);
  end
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .pend(pend), .busy(busy));

// File: tb/sim_lvl_irq_ctrl.sv
module sim_lvl_irq_ctrl;
  localparam int N_SRC = 40;
  localparam int N_CTX = 2;
  localparam int AW    = 26;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [N_SRC:1]   src = '0;
  logic [AW-1:0]    bus_addr = '0;
  logic [31:0]      bus_wdata = '0, bus_rdata;
  logic [N_CTX-1:0] irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PW(3), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq));

  function automatic logic [AW-1:0] a_pri(int id);          return AW'(4*id); endfunction
  function automatic logic [AW-1:0] a_en(int c, int w);     return AW'(32'h2000 + 128*c + 4*w); endfunction
  function automatic logic [AW-1:0] a_thr(int c);           return AW'(32'h200000 + 4096*c); endfunction
  function automatic logic [AW-1:0] a_clm(int c);           return AW'(32'h200004 + 4096*c); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] ad, logic [31:0] d);
    @(negedge clk); bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] ad, output logic [31:0] d);
    @(negedge clk); bus_addr = ad; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", 32'(irq), 0);
    rd(a_clm(0), v); check("R1 claim", v, 0);
    rd(a_pri(5), v); check("R1 prio", v, 0);
    rd(a_thr(1), v); check("R1 thr", v, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(a_pri(5), 32'hFF);         rd(a_pri(5), v);  check("R2 prio width", v, 32'h7);
    wr(a_en(0,1), 32'hFFFF_FFFF); rd(a_en(0,1), v); check("R2 enable word1", v, 32'h1FF);
    wr(a_thr(1), 32'h1F);         rd(a_thr(1), v);  check("R2 thr width", v, 32'h7);
    wr(a_en(0,1), 0); wr(a_thr(1), 0); wr(a_pri(5), 0);
  endtask

  task automatic t_holes;
    logic [31:0] v;
    wr(a_pri(0), 5);              rd(a_pri(0), v);  check("R3 id0 prio", v, 0);
    wr(a_en(0,0), 32'hFFFF_FFFF); rd(a_en(0,0), v); check("R3 enable bit0", v, 32'hFFFF_FFFE);
    wr(a_en(0,0), 0);
    wr(a_en(0,2), 32'hFFFF_FFFF); rd(a_en(0,2), v); check("R3 enable word2", v, 0);
    wr(a_en(2,0), 32'hFFFF_FFFF); rd(a_en(2,0), v); check("R3 enable ctx2", v, 0);
    wr(a_thr(2), 3);              rd(a_thr(2), v);  check("R3 thr ctx2", v, 0);
    wr(AW'(32'h200008), 3);       rd(AW'(32'h200008), v); check("R3 ctl off8", v, 0);
    rd(AW'(32'h1000), v);         check("R3 gap", v, 0);
  endtask

  task automatic t_thresh;
    logic [31:0] v;
    wr(a_pri(5), 3); wr(a_en(0,0), 32'h20); wr(a_thr(0), 3);
    src[5] = 1'b1; @(negedge clk); @(negedge clk);
    check("R4 equal to thr", 32'(irq[0]), 0);
    wr(a_thr(0), 2); check("R4 above thr", 32'(irq[0]), 1);
    wr(a_thr(0), 0); wr(a_pri(5), 0); check("R4 prio0", 32'(irq[0]), 0);
    rd(a_clm(0), v); check("R4 prio0 claim", v, 0);
    wr(a_pri(5), 3); check("R4 restore", 32'(irq[0]), 1);
    rd(a_clm(0), v); check("R5 single claim", v, 5);
    src[5] = 1'b0; wr(a_clm(0), 5); wr(a_en(0,0), 0);
    @(negedge clk); check("R7 idle", 32'(irq), 0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    wr(a_pri(7), 2); wr(a_pri(9), 5); wr(a_pri(35), 5);
    wr(a_en(0,0), (32'h1 << 7) | (32'h1 << 9)); wr(a_en(0,1), 32'h1 << 3);
    src[7] = 1'b1; src[9] = 1'b1; src[35] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(a_clm(0), v); check("R5 tie low id", v, 9);
    rd(a_clm(0), v); check("R5 second", v, 35);
    rd(a_clm(0), v); check("R5 lower prio", v, 7);
    rd(a_clm(0), v); check("R5 drained", v, 0);
    check("R6 irq low held", 32'(irq[0]), 0);
    src[7] = 1'b0; src[35] = 1'b0;
    wr(a_clm(0), 7); wr(a_clm(0), 35);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    @(negedge clk);
    rd(a_clm(0), v); check("R6 held line high", v, 0);
    wr(a_clm(0), 9); @(negedge clk);
    check("R7 repend irq", 32'(irq[0]), 1);
    rd(a_clm(0), v); check("R7 reclaim", v, 9);
  endtask

  task automatic t_wrong_ctx;
    logic [31:0] v;
    wr(a_clm(1), 9); @(negedge clk);
    check("R8 other ctx irq", 32'(irq[0]), 0);
    rd(a_clm(0), v); check("R8 other ctx claim", v, 0);
    wr(a_clm(0), 0); wr(a_clm(0), 41); @(negedge clk);
    check("R8 bad id", 32'(irq[0]), 0);
    wr(a_clm(0), 9); @(negedge clk);
    check("R7 complete", 32'(irq[0]), 1);
  endtask

  task automatic t_shared;
    logic [31:0] v;
    wr(a_en(1,0), 32'h1 << 9);
    check("R9 both raised", 32'(irq), 3);
    rd(a_clm(1), v); check("R9 ctx1 claim", v, 9);
    check("R9 both dropped", 32'(irq), 0);
    rd(a_clm(0), v); check("R9 ctx0 empty", v, 0);
    src[9] = 1'b0; wr(a_clm(1), 9); @(negedge clk);
    check("R9 idle", 32'(irq), 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_map; t_holes; t_thresh; t_order; t_gate; t_wrong_ctx; t_shared;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule